// File: doc/BRIEF.md
# External-Edge Clocked Counter

This block is a 16-bit event counter whose clock is an external input instead of the internal clock. The external level is first brought into the internal clock domain through a two-flop synchroniser. A polarity bit then chooses which edge of the pin is the active one. A programmable digital filter rejects short glitches. Its output feeds an edge detector and a power-of-two edge divider. The divider emits a single-cycle registered tick, and each tick advances the counter by one.

A user programs the filter length, the division ratio and the active edge while external clocking is off. The user then sets both the external-clock enable and the counter enable. From then on the counter follows the pin with a fixed lag of internal clock cycles. That lag grows by one cycle for each additional sample the filter demands.

The filter is a four-state machine:
- FLT_LOW: filtered output settled low.
- FLT_RISING: high samples are being counted while the output is still low.
- FLT_HIGH: filtered output settled high.
- FLT_FALLING: low samples are being counted while the output is still high.

Its transitions are:
- Arm-rise: FLT_LOW to FLT_RISING on a high sample.
- Abort-rise: FLT_RISING back to FLT_LOW on a low sample.
- Commit-rise: FLT_RISING to FLT_HIGH once enough high samples have been seen.
- Arm-fall, abort-fall and commit-fall: the mirror images of the three above.
- When the filter length is one sample, a commit is taken directly from a settled state.

Top module: `ext_edge_counter`

## Requirements
- R1: While `rst_n` is low, `count` is 0, and it stays 0 until counting is enabled.
- R2: With filter code 0, `edge_pol` = 0 and divide code 00, a rising input edge that is driven between clock edges is counted by the clock edge numbered 5 after the change. The first clock edge after the change is edge 1, and `count` still holds its old value after edge 4.
- R3: `edge_pol` = 0 selects rising edges of `ext_in` as the active edge. `edge_pol` = 1 selects falling edges; with `edge_pol` = 1, rising edges do not count.
- R4: `psc_code` divides active edges: 00 counts every edge, 01 every 2nd, 10 every 4th and 11 every 8th.
- R5: Filter code c > 0 requires 2^c consecutive equal synchronised samples before the filtered level changes, and code 0 requires one sample. A level that is held for fewer samples is ignored. Each extra required sample adds one cycle to the latency of R2.
- R6: While `ext_clk_en` is 0, no edge is counted and the divider phase is cleared. After re-enabling, a new full group of edges is needed for the next increment.
- R7: While `cnt_en` is 0, no edge is counted and `count` holds its value.
- R8: `count` increases by exactly one per tick and wraps from all ones to zero (0xFFFF to 0 at the default width).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_in | input | 1 | Raw external input, asynchronous to `clk` |
| flt_code | input | 4 | Filter setting; 0 means no filtering, c > 0 means 2^c samples |
| psc_code | input | 2 | Edge divide code: 00 /1, 01 /2, 10 /4, 11 /8 |
| edge_pol | input | 1 | 0 selects rising edges, 1 selects falling edges |
| ext_clk_en | input | 1 | Lets the conditioned external signal clock the counter |
| cnt_en | input | 1 | Counter enable |
| count | output | 16 | Counter value |

## Verification
An input change driven between clock edges reaches `count` at edge N+4, where N is the number of filter samples. The latency checks therefore sample one nanosecond after edge N+3 to see the old value, and again after edge N+4 to see the new one. All other checks wait a settle time of N+12 cycles after the last input change before comparing `count` with the bench model. This keeps them independent of the exact pipeline position. The bench holds every random input level for at least N cycles, and it changes polarity, filter or divider settings only while external clocking is off. As a result, the model's edge count is exact.

// File: rtl/ext_cnt_pkg.sv
package ext_cnt_pkg;

    typedef enum logic [1:0] {
        FLT_LOW     = 2'b00,
        FLT_RISING  = 2'b01,
        FLT_HIGH    = 2'b11,
        FLT_FALLING = 2'b10
    } flt_state_e;

endpackage

// File: rtl/ext_in_sync.sv
module ext_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic pol,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= din;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= chain_q[i-1];
        end

        // R2: each stage adds one cycle of delay
        a_r2_stage_shift: assert property (@(posedge clk) disable iff (!rst_n)
            chain_q[i] == $past(chain_q[i-1]));
    end

    // polarity applied after synchronisation: 1 turns falling pin edges into rising ones
    always_comb dout = chain_q[STAGES-1] ^ pol;

endmodule

// File: rtl/ext_edge_filter.sv
module ext_edge_filter
    import ext_cnt_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din,
    input  logic [CODE_W-1:0] code,
    output logic              dout
);
    localparam int RC_W = 1 << CODE_W;

    flt_state_e      state_q, state_d;
    logic [RC_W-1:0] run_q, run_d, last_run;

    // number of samples still needed after the first, minus nothing: N-1
    always_comb begin
        if (code == '0) last_run = '0;
        else            last_run = RC_W'((32'd1 << code) - 32'd1);
    end

    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        unique case (state_q)
            FLT_LOW: begin
                if (din) begin
                    if (last_run == '0) begin
                        state_d = FLT_HIGH;
                        run_d   = '0;
                    end else begin
                        state_d = FLT_RISING;
                        run_d   = RC_W'(1);
                    end
                end
            end
            FLT_RISING: begin
                if (!din) begin
                    state_d = FLT_LOW;
                    run_d   = '0;
                end else if (run_q >= last_run) begin
                    state_d = FLT_HIGH;
                    run_d   = '0;
                end else begin
                    run_d = run_q + RC_W'(1);
                end
            end
            FLT_HIGH: begin
                if (!din) begin
                    if (last_run == '0) begin
                        state_d = FLT_LOW;
                        run_d   = '0;
                    end else begin
                        state_d = FLT_FALLING;
                        run_d   = RC_W'(1);
                    end
                end
            end
            FLT_FALLING: begin
                if (din) begin
                    state_d = FLT_HIGH;
                    run_d   = '0;
                end else if (run_q >= last_run) begin
                    state_d = FLT_LOW;
                    run_d   = '0;
                end else begin
                    run_d = run_q + RC_W'(1);
                end
            end
            default: begin
                state_d = FLT_LOW;
                run_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_LOW;
            run_q   <= '0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
        end
    end

    always_comb dout = (state_q == FLT_HIGH) || (state_q == FLT_FALLING);

    // R5: the filtered level only ever moves to the level last sampled
    a_r5_follows_sample: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout) |-> dout == $past(din));
    // R5: a pending rise is dropped by one opposite sample
    a_r5_abort_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FLT_RISING && !din) |=> state_q == FLT_LOW);
    // R5: a pending fall is dropped by one opposite sample
    a_r5_abort_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FLT_FALLING && din) |=> state_q == FLT_HIGH);

endmodule

// File: rtl/ext_edge_prescaler.sv
module ext_edge_prescaler #(
    parameter int CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flt,
    input  logic [CODE_W-1:0] code,
    input  logic              run_en,
    output logic              tick
);
    localparam int PC_W = ((1 << CODE_W) - 1) > 0 ? ((1 << CODE_W) - 1) : 1;

    logic            prev_q;
    logic            rise;
    logic [PC_W-1:0] phase_q;
    logic [PC_W-1:0] last_idx;

    always_comb begin
        rise     = flt && !prev_q;
        last_idx = PC_W'((32'd1 << code) - 32'd1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            phase_q <= '0;
            tick    <= 1'b0;
        end else begin
            prev_q <= flt;
            if (!run_en) begin
                phase_q <= '0;
                tick    <= 1'b0;
            end else if (rise) begin
                if (phase_q >= last_idx) begin
                    phase_q <= '0;
                    tick    <= 1'b1;
                end else begin
                    phase_q <= phase_q + PC_W'(1);
                    tick    <= 1'b0;
                end
            end else begin
                tick <= 1'b0;
            end
        end
    end

    // R2: a tick lasts one cycle
    a_r2_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    // R6: nothing is emitted while external clocking or counting is off
    a_r6_idle_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !tick);
    // R4: a tick is only issued from a high filtered level
    a_r4_tick_from_edge: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(flt));

endmodule

// File: rtl/ext_edge_counter.sv
module ext_edge_counter #(
    parameter int CNT_W       = 16,
    parameter int FLT_CODE_W  = 4,
    parameter int PSC_CODE_W  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ext_in,
    input  logic [FLT_CODE_W-1:0] flt_code,
    input  logic [PSC_CODE_W-1:0] psc_code,
    input  logic                  edge_pol,
    input  logic                  ext_clk_en,
    input  logic                  cnt_en,
    output logic [CNT_W-1:0]      count
);
    logic sync_lvl;
    logic flt_lvl;
    logic tick;
    logic run_en;

    always_comb run_en = ext_clk_en && cnt_en;

    ext_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ext_in),
        .pol  (edge_pol),
        .dout (sync_lvl)
    );

    ext_edge_filter #(.CODE_W(FLT_CODE_W)) u_filter (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (sync_lvl),
        .code (flt_code),
        .dout (flt_lvl)
    );

    ext_edge_prescaler #(.CODE_W(PSC_CODE_W)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .flt   (flt_lvl),
        .code  (psc_code),
        .run_en(run_en),
        .tick  (tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                count <= '0;
        else if (tick && run_en)   count <= count + CNT_W'(1);
    end

    // R8: the value only ever steps up by one, wrapping at the width
    a_r8_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(count) |-> count == $past(count) + CNT_W'(1));
    // R7: counter enable low freezes the value
    a_r7_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> $stable(count));
    // R6: external-clock enable low freezes the value
    a_r6_hold_when_ext_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_clk_en |=> $stable(count));

endmodule

// File: tb/ext_edge_counter_bench.sv
`timescale 1ns/1ps
module ext_edge_counter_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ext_in;
    logic [3:0]  flt_code;
    logic [1:0]  psc_code;
    logic        edge_pol;
    logic        ext_clk_en;
    logic        cnt_en;
    logic [15:0] count;
    logic [7:0]  count_w;

    int   n_tests = 0;
    int   n_fail  = 0;
    int   m_cnt   = 0;
    int   m_ph    = 0;
    logic m_lvl   = 1'b0;
    bit   done    = 1'b0;

    always #2 clk = ~clk;

    ext_edge_counter u_ext_edge_counter (
        .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .flt_code(flt_code),
        .psc_code(psc_code), .edge_pol(edge_pol), .ext_clk_en(ext_clk_en),
        .cnt_en(cnt_en), .count(count)
    );

    ext_edge_counter #(.CNT_W(8)) u_ext_edge_counter_w (
        .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .flt_code(flt_code),
        .psc_code(psc_code), .edge_pol(edge_pol), .ext_clk_en(ext_clk_en),
        .cnt_en(cnt_en), .count(count_w)
    );

    function automatic int filt_len(input logic [3:0] c);
        return (c == 4'd0) ? 1 : (1 << c);
    endfunction

    task automatic chk(input string req, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // drive a level at a negedge and hold it n cycles; model counts filtered rises
    task automatic drive(input logic v, input int n);
        if (v != m_lvl) begin
            if (((v ^ edge_pol) == 1'b1) && ext_clk_en && cnt_en) begin
                m_ph++;
                if (m_ph >= (1 << psc_code)) begin
                    m_ph = 0;
                    m_cnt++;
                end
            end
            m_lvl = v;
        end
        ext_in = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse();
        drive(1'b1, filt_len(flt_code) + 1);
        drive(1'b0, filt_len(flt_code) + 1);
    endtask

    task automatic settle();
        repeat (12 + filt_len(flt_code)) @(negedge clk);
    endtask

    task automatic check_count(input string req);
        settle();
        chk(req, int'(count), m_cnt & 16'hFFFF);
        chk(req, int'(count_w), m_cnt & 8'hFF);
    endtask

    task automatic set_en(input logic x, input logic c);
        ext_clk_en = x;
        cnt_en     = c;
        if (!(x && c)) m_ph = 0;
    endtask

    task automatic configure(input logic pol, input logic [1:0] psc, input logic [3:0] flt);
        set_en(1'b0, cnt_en);
        settle();
        edge_pol = pol;
        psc_code = psc;
        flt_code = flt;
        settle();
        set_en(1'b1, 1'b1);
    endtask

    initial begin
        int base;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; ext_in = 1'b0; flt_code = 4'd0; psc_code = 2'd0;
        edge_pol = 1'b0; ext_clk_en = 1'b0; cnt_en = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1 reset value", int'(count), 0);
        rst_n = 1'b1;
        pulse();
        check_count("R1 idle after reset");

        // R2: exact latency with no filter
        set_en(1'b1, 1'b1);
        settle();
        base = int'(count);
        ext_in = 1'b1; m_lvl = 1'b1; m_cnt++;
        repeat (4) @(posedge clk);
        #1 chk("R2 before edge 5", int'(count), base);
        @(posedge clk);
        #1 chk("R2 at edge 5", int'(count), base + 1);
        @(negedge clk);
        drive(1'b0, 4);

        // R5: latency with 4-sample filter
        configure(1'b0, 2'd0, 4'd2);
        base = int'(count);
        ext_in = 1'b1; m_lvl = 1'b1; m_cnt++;
        repeat (7) @(posedge clk);
        #1 chk("R5 before edge 8", int'(count), base);
        @(posedge clk);
        #1 chk("R5 at edge 8", int'(count), base + 1);
        @(negedge clk);
        drive(1'b0, 6);

        // R5: glitch of 3 samples ignored, 4 samples accepted
        settle();
        base = int'(count);
        ext_in = 1'b1;
        repeat (3) @(negedge clk);
        ext_in = 1'b0;
        settle();
        chk("R5 short glitch ignored", int'(count), base);
        drive(1'b1, 4);
        drive(1'b0, 6);
        check_count("R5 exact length accepted");
        chk("R5 exact length increment", int'(count), base + 1);

        // R3: falling-edge polarity
        configure(1'b1, 2'd0, 4'd0);
        base = int'(count);
        drive(1'b1, 3);
        check_count("R3 rising ignored");
        chk("R3 rising ignored value", int'(count), base);
        drive(1'b0, 3);
        check_count("R3 falling counted");
        chk("R3 falling increment", int'(count), base + 1);

        // R4: each divide code over 8 edges
        for (int p = 0; p < 4; p++) begin
            configure(1'b0, 2'(p), 4'd0);
            base = int'(count);
            repeat (8) pulse();
            check_count("R4 divide");
            chk("R4 divide increment", int'(count) - base, 8 >> p);
        end

        // R6: disabling clears the divider phase
        configure(1'b0, 2'd1, 4'd0);
        base = int'(count);
        pulse();
        set_en(1'b0, 1'b1);
        pulse();
        settle();
        set_en(1'b1, 1'b1);
        pulse();
        check_count("R6 phase cleared");
        chk("R6 no count after restart", int'(count), base);
        pulse();
        check_count("R6 full group counts");
        chk("R6 increment after group", int'(count), base + 1);

        // R7: counter enable low
        configure(1'b0, 2'd0, 4'd0);
        set_en(1'b1, 1'b0);
        base = int'(count);
        repeat (5) pulse();
        check_count("R7 frozen");
        chk("R7 frozen value", int'(count), base);
        set_en(1'b1, 1'b1);

        // R8: wrap of the narrow instance, step of the wide one
        while ((m_cnt & 8'hFF) != 8'hFE) pulse();
        check_count("R8 before wrap");
        pulse();
        check_count("R8 at all ones");
        chk("R8 narrow at all ones", int'(count_w), 255);
        pulse();
        check_count("R8 wrap");
        chk("R8 narrow wrapped", int'(count_w), 0);

        // random levels and settings (R2 R3 R4 R5)
        for (int it = 0; it < 400; it++) begin
            if (it % 40 == 0)
                configure(1'($urandom % 2), 2'($urandom % 4), 4'($urandom % 4));
            drive(1'($urandom % 2), filt_len(flt_code) + 1 + int'($urandom % 4));
            if (it % 20 == 19) check_count("R4 random mix");
        end
        check_count("R5 random final");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule